// File: doc/BRIEF.md
# Configurable HDLC Receiver Front End

This block sits between a serial bit line and a receive FIFO. Each received bit arrives with a one-cycle bit-clock enable. Finished bytes leave through a push interface, one push per cycle at most.

The block has two modes. In framed mode it finds 0x7E flags and strips the zero inserted after five ones. It assembles bytes with the least significant bit first, checks the 16-bit frame check sequence, and ends each frame with a status push. In transparent mode it packs raw bits into bytes. It can first hunt for an 8-bit pattern so that byte boundaries lock to the point where the pattern matches.

A small register interface holds the mode, the alignment enable, the alignment pattern and a control that suppresses the two check bytes. None of these settings acts on the receiver until an initialize sequence runs. The initialize bit clears itself and is also run automatically after reset. The FIFO storage, the host bus decoder, the transmitter and interrupts sit outside this block.

Top module: `hdlc_rx_front`

## Requirements
- R1: Register address 0 is the configuration register: bit 0 is the initialize/busy bit, bit 1 selects transparent mode (0 = framed), bit 2 enables pattern alignment, bit 3 suppresses the check bytes, and bits 7:4 always read 0. Address 1 holds the 8-bit alignment pattern. Writing 0 to bit 0 starts nothing.
- R2: Writing address 0 with bit 0 = 1 makes bit 0 read 1 for exactly 4 clock cycles after the write edge, then 0. Bit 0 also reads 1 for the first 4 cycles after reset.
- R3: The mode, alignment enable, pattern and suppress settings reach the receiver only when an initialize completes. Writing them without an initialize leaves the receiver's behaviour unchanged.
- R4: An initialize clears the destuffing count, the shift register, the bit position, the check accumulator and the alignment state. Bits presented while it runs are ignored, and no push follows a busy cycle.
- R5: In framed mode, 0x7E opens and closes frames, a 0 that follows five 1s is removed, and each completed byte is pushed with pushEnd = 0. The first received bit of a byte lands in bit 0.
- R6: At a closing flag of a frame that produced at least one byte, an end push is made with pushEnd = 1 and pushData = 0x00. In that push, pushGood = 1 only if the frame holds a whole number of bytes and the check accumulator (preset 0xFFFF, reflected polynomial 0x8408) ends at 0xF0B8. Back-to-back flags produce no push.
- R7: Seven consecutive 1s abort a frame. If the frame had produced a byte, an end push with pushGood = 0 follows. The receiver then waits for the next flag.
- R8: With suppression off, the two check bytes are pushed like data. With it on, the last two bytes before the closing flag are never pushed.
- R9: In transparent mode with alignment off, every 8 bits after an initialize yield a byte push, and no end push is ever made.
- R10: In transparent mode with alignment on, no byte is pushed until the last 8 bits (newest bit in bit 7) equal the pattern. That byte is pushed, and every following 8 bits yield a byte.
- R11: pushGood is only 1 with pushEnd, and pushEnd is only 1 with pushValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | Qualifies bitIn for one cycle |
| bitIn | input | 1 | Serial receive bit |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 pattern |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| pushValid | output | 1 | Push into the receive FIFO |
| pushData | output | 8 | Pushed byte, 0x00 on an end push |
| pushEnd | output | 1 | Marks the end-of-frame status push |
| pushGood | output | 1 | Frame check status on an end push |

## Verification
A corrupted destuffing count or bit position shows at the ports within one byte time: bytes come out shifted, and the next end push reports bad status. A wrongly latched setting shows on the next byte push after an initialize. A shortened or lengthened initialize shows directly in the bit 0 readback. Transparent alignment errors show as wrong data on the first byte after the pattern.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int POS_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic              clear;
    logic              bitStb;
    logic              transparent;
    logic              alignEn;
    logic              dropCrc;
    logic [BYTE_W-1:0] pattern;
  } rxCtrl_t;
endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int INIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output rxCtrl_t           ctl
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0]  initCnt;
  logic              cfgMode, cfgAlign, cfgDrop;
  logic [BYTE_W-1:0] cfgPattern;
  logic              actMode, actAlign, actDrop;
  logic [BYTE_W-1:0] actPattern;
  logic              busy, startInit;
  logic              unusedHiBits;

  assign busy         = (initCnt != '0);
  assign startInit    = regWr && !regAddr && regWdata[0];
  assign unusedHiBits = ^regWdata[BYTE_W-1:4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt    <= CNT_W'(INIT_CYCLES);
      cfgMode    <= 1'b0;
      cfgAlign   <= 1'b0;
      cfgDrop    <= 1'b0;
      cfgPattern <= '0;
      actMode    <= 1'b0;
      actAlign   <= 1'b0;
      actDrop    <= 1'b0;
      actPattern <= '0;
    end else begin
      if (regWr && !regAddr) begin
        cfgMode  <= regWdata[1];
        cfgAlign <= regWdata[2];
        cfgDrop  <= regWdata[3];
      end
      if (regWr && regAddr) cfgPattern <= regWdata;

      if (startInit) initCnt <= CNT_W'(INIT_CYCLES);
      else if (busy) initCnt <= initCnt - CNT_W'(1);

      // settings are captured in the last busy cycle
      if (!startInit && initCnt == CNT_W'(1)) begin
        actMode    <= cfgMode;
        actAlign   <= cfgAlign;
        actDrop    <= cfgDrop;
        actPattern <= cfgPattern;
      end
    end
  end

  always_comb begin
    if (regAddr) regRdata = cfgPattern;
    else         regRdata = {4'b0000, cfgDrop, cfgAlign, cfgMode, busy};
  end

  always_comb begin
    ctl.clear       = busy;
    ctl.bitStb      = bitEn && !busy;
    ctl.transparent = actMode;
    ctl.alignEn     = actAlign;
    ctl.dropCrc     = actDrop;
    ctl.pattern     = actPattern;
  end
endmodule

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_PRESET  = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtrl_t           ctl,
  input  logic              bitIn,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData,
  output logic              pushEnd,
  output logic              pushGood
);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(BYTE_W - 1);
  localparam logic [POS_W-1:0] FLAG_POS  = POS_W'(BYTE_W - 2);

  logic [2:0]        ones, onesN;
  logic              inFrame, inFrameN, gotByte, gotByteN;
  logic [POS_W-1:0]  bitPos, bitPosN;
  logic [BYTE_W-1:0] shiftReg, srN;
  logic [15:0]       crc, crcN;
  logic [BYTE_W-1:0] hold1, hold1N, hold2, hold2N;
  logic [1:0]        holdCnt, holdCntN;
  logic              locked, lockedN;
  logic [POS_W-1:0]  fill, fillN;
  logic              pValN, pEndN, pGoodN, isData;
  logic [BYTE_W-1:0] pDataN;

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_POLY : 16'h0000);
    return r;
  endfunction

  always_comb begin
    onesN = ones;  inFrameN = inFrame;  gotByteN = gotByte;  bitPosN = bitPos;
    srN = shiftReg;  crcN = crc;  hold1N = hold1;  hold2N = hold2;
    holdCntN = holdCnt;  lockedN = locked;  fillN = fill;
    pValN = 1'b0;  pDataN = '0;  pEndN = 1'b0;  pGoodN = 1'b0;  isData = 1'b0;
    if (ctl.clear) begin
      onesN = '0;  inFrameN = 1'b0;  gotByteN = 1'b0;  bitPosN = '0;  srN = '0;
      crcN = CRC_PRESET;  holdCntN = '0;  lockedN = 1'b0;  fillN = '0;
    end else if (ctl.bitStb) begin
      if (ctl.transparent) begin
        srN = {bitIn, shiftReg[BYTE_W-1:1]};
        if (locked || !ctl.alignEn) begin
          bitPosN = bitPos + POS_W'(1);
          if (bitPos == LAST_POS) begin
            pValN  = 1'b1;
            pDataN = srN;
          end
        end else begin
          if (fill != LAST_POS) fillN = fill + POS_W'(1);
          if (fill == LAST_POS && srN == ctl.pattern) begin
            lockedN = 1'b1;
            bitPosN = '0;
            pValN   = 1'b1;
            pDataN  = srN;
          end
        end
      end else begin
        if (bitIn) begin
          if (ones != 3'd7) onesN = ones + 3'd1;
          if (ones == 3'd6) begin
            // seventh one in a row: abort
            if (inFrame && gotByte) begin
              pValN = 1'b1;
              pEndN = 1'b1;
            end
            inFrameN = 1'b0;
          end else if (ones < 3'd5) begin
            isData = 1'b1;
          end
        end else begin
          onesN = '0;
          if (ones == 3'd6) begin
            if (inFrame && gotByte) begin
              pValN  = 1'b1;
              pEndN  = 1'b1;
              pGoodN = (bitPos == FLAG_POS) && (crc == CRC_RESIDUE);
            end
            inFrameN = 1'b1;  gotByteN = 1'b0;  bitPosN = '0;
            crcN = CRC_PRESET;  holdCntN = '0;
          end else if (ones != 3'd5) begin
            isData = 1'b1;
          end
        end
        if (isData && inFrame) begin
          srN     = {bitIn, shiftReg[BYTE_W-1:1]};
          bitPosN = bitPos + POS_W'(1);
          if (bitPos == LAST_POS) begin
            gotByteN = 1'b1;
            crcN     = crcByte(crc, srN);
            if (!ctl.dropCrc) begin
              pValN  = 1'b1;
              pDataN = srN;
            end else begin
              if (holdCnt == 2'd2) begin
                pValN  = 1'b1;
                pDataN = hold2;
              end
              hold2N = hold1;
              hold1N = srN;
              if (holdCnt != 2'd2) holdCntN = holdCnt + 2'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ones <= '0;  inFrame <= 1'b0;  gotByte <= 1'b0;  bitPos <= '0;  shiftReg <= '0;
      crc <= CRC_PRESET;  hold1 <= '0;  hold2 <= '0;  holdCnt <= '0;
      locked <= 1'b0;  fill <= '0;
      pushValid <= 1'b0;  pushData <= '0;  pushEnd <= 1'b0;  pushGood <= 1'b0;
    end else begin
      ones <= onesN;  inFrame <= inFrameN;  gotByte <= gotByteN;  bitPos <= bitPosN;
      shiftReg <= srN;  crc <= crcN;  hold1 <= hold1N;  hold2 <= hold2N;
      holdCnt <= holdCntN;  locked <= lockedN;  fill <= fillN;
      pushValid <= pValN;  pushData <= pDataN;  pushEnd <= pEndN;  pushGood <= pGoodN;
    end
  end
endmodule

// File: rtl/hdlc_rx_front.sv
module hdlc_rx_front
  import hdlc_rx_pkg::*;
#(
  parameter int INIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       regWr,
  input  logic       regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       pushValid,
  output logic [7:0] pushData,
  output logic       pushEnd,
  output logic       pushGood
);
  rxCtrl_t ctl;

  hdlc_rx_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl)
  );

  hdlc_rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(bitIn),
    .pushValid(pushValid), .pushData(pushData), .pushEnd(pushEnd), .pushGood(pushGood)
  );
endmodule

// File: rtl/hdlc_rx_front_chk.sv
module hdlc_rx_front_chk
  import hdlc_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic       regAddr,
  input logic [7:0] regWdata,
  input logic       pushValid,
  input logic       pushEnd,
  input logic       pushGood,
  input rxCtrl_t    ctl
);
  // R2
  init_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regAddr && regWdata[0]) |=> ctl.clear);

  // R4
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> !pushValid);

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !$past(ctl.clear)) |->
      $stable({ctl.transparent, ctl.alignEn, ctl.dropCrc, ctl.pattern}));

  // R9
  transp_noend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && ctl.transparent) |-> !pushEnd);

  // R11
  end_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushEnd |-> pushValid);

  // R11
  good_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushGood |-> pushEnd);
endmodule

bind hdlc_rx_front hdlc_rx_front_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .pushValid(pushValid), .pushEnd(pushEnd), .pushGood(pushGood), .ctl(ctl)
);

// File: tb/hdlc_rx_front_tb.sv
module hdlc_rx_front_tb;
  logic clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, bitIn = 1'b0, regWr = 1'b0, regAddr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata, pushData;
  logic pushValid, pushEnd, pushGood;

  int checks = 0, errors = 0, txOnes = 0;
  bit finished = 0;
  string curReq = "R5";
  logic [9:0] expQ[$];
  logic [9:0] expHead;

  always #5 clk = ~clk;

  hdlc_rx_front u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pushValid(pushValid), .pushData(pushData),
    .pushEnd(pushEnd), .pushGood(pushGood)
  );

  // per-clock comparison against the expected push stream
  always @(negedge clk) begin
    if (rstN && pushValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected push end=%0b good=%0b data=%02h, expected none",
                 curReq, pushEnd, pushGood, pushData);
      end else begin
        expHead = expQ.pop_front();
        if ({pushEnd, pushGood, pushData} !== expHead) begin
          errors++;
          $display("FAIL %s: push end=%0b good=%0b data=%02h, expected end=%0b good=%0b data=%02h",
                   curReq, pushEnd, pushGood, pushData, expHead[9], expHead[8], expHead[7:0]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkDrained(input string req);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d pushes missing, expected 0", req, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWr = 1'b0; regAddr = 1'b0;
  endtask

  task automatic doInit(input logic [7:0] cfg);
    wrReg(1'b0, cfg | 8'h01);
    repeat (5) tick();
  endtask

  task automatic sendBit(input logic b);
    bitIn = b; bitEn = 1'b1;
    tick();
    bitEn = 1'b0;
    tick();
  endtask

  task automatic sendRaw(input logic [7:0] d);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
  endtask

  task automatic sendFlag();
    sendRaw(8'h7E);
    txOnes = 0;
  endtask

  task automatic sendStuffed(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sendBit(d[i]);
      if (d[i]) txOnes++; else txOnes = 0;
      if (txOnes == 5) begin
        sendBit(1'b0);
        txOnes = 0;
      end
    end
  endtask

  function automatic logic [15:0] benchCrc(input logic [7:0] q[$]);
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (q[i])
      for (int b = 0; b < 8; b++)
        if (c[0] ^ q[i][b]) c = (c >> 1) ^ 16'h8408; else c = c >> 1;
    return c;
  endfunction

  task automatic sendFrame(input logic [7:0] q[$], input bit corrupt, input bit drop);
    logic [15:0] fcs;
    fcs = ~benchCrc(q);
    if (corrupt) fcs[0] = ~fcs[0];
    foreach (q[i]) expQ.push_back({2'b00, q[i]});
    if (!drop) begin
      expQ.push_back({2'b00, fcs[7:0]});
      expQ.push_back({2'b00, fcs[15:8]});
    end
    expQ.push_back({1'b1, !corrupt, 8'h00});
    sendFlag();
    foreach (q[i]) sendStuffed(q[i]);
    sendStuffed(fcs[7:0]);
    sendStuffed(fcs[15:8]);
    sendFlag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R2 automatic initialize after reset
    check("R2 busy after reset", regRdata, 8'h01);
    repeat (4) tick();
    check("R2 busy clears after reset", regRdata, 8'h00);

    // R2 initialize lasts exactly 4 cycles
    wrReg(1'b0, 8'h01);
    for (int i = 0; i < 4; i++) begin
      check("R2 busy during initialize", regRdata, 8'h01);
      tick();
    end
    check("R2 busy cleared", regRdata, 8'h00);

    // R1 register layout, reserved bits read 0, bit0=0 starts nothing
    wrReg(1'b0, 8'hFE);
    check("R1 config readback", regRdata, 8'h0E);
    wrReg(1'b1, 8'h5C);
    regAddr = 1'b1;
    check("R1 pattern readback", regRdata, 8'h5C);
    regAddr = 1'b0;

    // R5 R6 R8 framed mode, check bytes kept; data exercising stuffing
    doInit(8'h00);
    curReq = "R5";
    sendFrame('{8'h7E, 8'hFF, 8'h01, 8'hF8}, 1'b0, 1'b0);
    checkDrained("R5 good frame");
    curReq = "R6";
    sendFlag(); sendFlag(); sendFlag();
    checkDrained("R6 idle flags");
    sendFrame('{8'h3C, 8'h1F}, 1'b1, 1'b0);
    checkDrained("R6 bad check sequence");

    // R7 abort after two bytes
    curReq = "R7";
    sendFlag();
    expQ.push_back({2'b00, 8'h12});
    expQ.push_back({2'b00, 8'h34});
    expQ.push_back({2'b10, 8'h00});
    sendStuffed(8'h12);
    sendStuffed(8'h34);
    for (int i = 0; i < 11; i++) sendBit(1'b1);
    checkDrained("R7 abort");
    sendFrame('{8'hA0}, 1'b0, 1'b0);
    checkDrained("R7 recovery");

    // R3 settings written without initialize have no effect
    curReq = "R3";
    wrReg(1'b0, 8'h0A);
    check("R3 written but not active", regRdata, 8'h0A);
    sendFrame('{8'h55, 8'hC3}, 1'b0, 1'b0);
    checkDrained("R3 still framed, check bytes kept");

    // R8 suppression after initialize
    curReq = "R8";
    doInit(8'h08);
    sendFrame('{8'h01, 8'h02, 8'h03}, 1'b0, 1'b1);
    checkDrained("R8 check bytes dropped");
    sendFrame('{8'hEE}, 1'b0, 1'b1);
    checkDrained("R8 short frame dropped bytes");

    // R4 partial byte, bits during initialize ignored, then R9 packing
    curReq = "R4";
    doInit(8'h02);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    wrReg(1'b0, 8'h03);
    sendBit(1'b1);
    sendBit(1'b1);
    tick();
    expQ.push_back({2'b00, 8'h3C});
    sendRaw(8'h3C);
    checkDrained("R4 state cleared by initialize");
    curReq = "R9";
    expQ.push_back({2'b00, 8'h81});
    expQ.push_back({2'b00, 8'h7E});
    sendRaw(8'h81);
    sendRaw(8'h7E);
    checkDrained("R9 transparent bytes, flag not special");

    // R10 alignment to pattern 0xA5
    curReq = "R10";
    wrReg(1'b1, 8'hA5);
    doInit(8'h06);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    expQ.push_back({2'b00, 8'hA5});
    expQ.push_back({2'b00, 8'h5A});
    expQ.push_back({2'b00, 8'h0F});
    sendRaw(8'hA5);
    sendRaw(8'h5A);
    sendRaw(8'h0F);
    checkDrained("R10 aligned bytes");
    check("R11 no stray push", {7'd0, pushValid}, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule